// File: doc/BRIEF.md
# Memory Mode Register Init Sequencer

This block drives the power-up mode-register programming of a low-power DRAM channel. A one-cycle start pulse begins an initial settle wait. The block then walks a fixed list of six mode-register commands. For each command it presents a command word on the command bus, raises a request strobe, and keeps the strobe high for that command's minimum time. It then drops the strobe for a short gap before the next command.

The command list always begins with the device reset write, followed by the ZQ initialisation write. After those come the I/O drive-strength write, the two general configuration writes, and finally the on-die-termination write. The register values come from static configuration inputs. The whole list is replayed for rank 1 only when the channel's dual-rank bit in a configuration word is set. When the last command of the last rank has finished, a done flag pulses for one cycle. The DRAM pins and the PHY sit outside this block. All times are counted in clock cycles and set by parameters.

Top module: `mrinit_seq`

## Requirements
- R1: Out of reset, `cmd_req_o`, `done_o` and `cmd_word_o` are all 0, and nothing is issued until a start pulse arrives.
- R2: The first strobe rises exactly `SETTLE_CYC` cycles after the clock edge that samples `start_i` high.
- R3: Within a rank, commands are issued in this order of values: reset, ZQ init, drive strength, configuration A, configuration B, ODT.
- R4: While the strobe is high, bits 31:28 of the command word hold the rank number (0 or 1) and bits 27:0 hold the register value. The word is stable for the whole strobe.
- R5: The strobe stays high for exactly `LONG_HOLD_CYC` cycles for the reset command and exactly `SHORT_HOLD_CYC` cycles for every other command.
- R6: Between two strobes the strobe is low for exactly `GAP_CYC` cycles. This includes the step from rank 0 to rank 1. While the strobe is low, the command word reads 0.
- R7: The command list is replayed for rank 1 only when the dual-rank bit is 1. That bit is `rank_cfg_i[17]` when `chan_sel_i`=0 and `rank_cfg_i[16]` when `chan_sel_i`=1; the other bit has no effect.
- R8: `done_o` is high for exactly one cycle, `GAP_CYC` cycles after the last strobe falls. It pulses once per run.
- R9: A start pulse that arrives while a run is in progress is ignored. The run keeps its timing, and no second run follows.
- R10: The dual-rank decision is captured at start. A change of `rank_cfg_i` during a run does not alter the number of ranks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to begin the sequence |
| chan_sel_i | input | 1 | Channel index that selects the dual-rank bit |
| rank_cfg_i | input | 32 | Configuration word holding the dual-rank bits (17 and 16) |
| mr_reset_val_i | input | 28 | Value field of the reset command |
| mr_zqinit_val_i | input | 28 | Value field of the ZQ init command |
| mr_iostr_val_i | input | 28 | Value field of the drive-strength command |
| mr_cfga_val_i | input | 28 | Value field of configuration command A |
| mr_cfgb_val_i | input | 28 | Value field of configuration command B |
| mr_odt_val_i | input | 28 | Value field of the ODT command |
| cmd_word_o | output | 32 | Command word: rank in 31:28, value in 27:0; 0 while idle |
| cmd_req_o | output | 1 | Command request strobe |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Runs are made with the two channel selects crossed with configuration words that set only bit 17 or only bit 16. Comparing their command counts shows whether the dual-rank bit is taken from the correct position and whether the opposite bit is ignored. Six distinct value fields make any reordering or mix-up of commands visible in the recorded words. The per-strobe lengths and gaps show whether the long reset hold is confined to the first command of each rank. One run injects a second start mid-sequence, and another flips the configuration word mid-sequence. In both cases the recorded stream must match a clean single run, which separates start-gating and at-start capture from live sampling.

// File: rtl/mrinit_pkg.sv
package mrinit_pkg;
  localparam int unsigned NUM_CMDS = 6;
  localparam int unsigned IDX_W    = $clog2(NUM_CMDS);
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned VAL_W    = 28;
  localparam int unsigned RANK_LSB = 28;
  localparam int unsigned DUAL_BIT_CH0 = 17;
  localparam int unsigned DUAL_BIT_CH1 = 16;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETTLE, ST_ISSUE, ST_GAP, ST_DONE
  } seq_state_t;

  function automatic logic [WORD_W-1:0] pack_cmd(input logic rank,
                                                 input logic [VAL_W-1:0] val);
    logic [WORD_W-1:0] w;
    w = '0;
    w[VAL_W-1:0] = val;
    w = w | (WORD_W'(rank) << RANK_LSB);
    return w;
  endfunction

  function automatic logic dual_from_cfg(input logic [31:0] cfg, input logic chan);
    return chan ? cfg[DUAL_BIT_CH1] : cfg[DUAL_BIT_CH0];
  endfunction

  function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                       input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction
endpackage

// File: rtl/mrinit_timer.sv
module mrinit_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (load_i)           cnt_q <= load_val_i;
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);

  // R5
  load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> cnt_q == $past(load_val_i));

  // R2
  count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/mrinit_cmdrom.sv
module mrinit_cmdrom
  import mrinit_pkg::*;
#(
  parameter int unsigned CNT_W          = 16,
  parameter int unsigned LONG_HOLD_CYC  = 2000,
  parameter int unsigned SHORT_HOLD_CYC = 200
) (
  input  logic [IDX_W-1:0] idx_i,
  input  logic [VAL_W-1:0] reset_val_i,
  input  logic [VAL_W-1:0] zqinit_val_i,
  input  logic [VAL_W-1:0] iostr_val_i,
  input  logic [VAL_W-1:0] cfga_val_i,
  input  logic [VAL_W-1:0] cfgb_val_i,
  input  logic [VAL_W-1:0] odt_val_i,
  output logic [VAL_W-1:0] val_o,
  output logic [CNT_W-1:0] hold_o
);
  logic [VAL_W-1:0] table_v [NUM_CMDS];

  function automatic logic [CNT_W-1:0] hold_for(input logic [IDX_W-1:0] i);
    return (i == '0) ? CNT_W'(LONG_HOLD_CYC) : CNT_W'(SHORT_HOLD_CYC);
  endfunction

  always_comb begin
    table_v[0] = reset_val_i;
    table_v[1] = zqinit_val_i;
    table_v[2] = iostr_val_i;
    table_v[3] = cfga_val_i;
    table_v[4] = cfgb_val_i;
    table_v[5] = odt_val_i;
  end

  always_comb begin
    val_o = '0;
    for (int k = 0; k < NUM_CMDS; k++)
      if (idx_i == IDX_W'(k)) val_o = table_v[k];
    hold_o = hold_for(idx_i);
  end
endmodule

// File: rtl/mrinit_ctrl.sv
module mrinit_ctrl
  import mrinit_pkg::*;
#(
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned SETTLE_CYC = 40000,
  parameter int unsigned GAP_CYC    = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             dual_cfg_i,
  input  logic             tmr_zero_i,
  input  logic [CNT_W-1:0] cur_hold_i,
  output seq_state_t       state_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             rank_o,
  output logic             tmr_load_o,
  output logic [CNT_W-1:0] tmr_val_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_CMDS - 1);

  seq_state_t       st_q, st_n;
  logic [IDX_W-1:0] idx_q, idx_n;
  logic             rank_q, rank_n, dual_q, dual_n, fin_q, fin_n;

  always_comb begin
    st_n = st_q; idx_n = idx_q; rank_n = rank_q; dual_n = dual_q; fin_n = fin_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    unique case (st_q)
      ST_IDLE: if (start_i) begin
        st_n = ST_SETTLE; dual_n = dual_cfg_i;
        idx_n = '0; rank_n = 1'b0; fin_n = 1'b0;
        tmr_load_o = 1'b1; tmr_val_o = CNT_W'(SETTLE_CYC - 1);
      end
      ST_SETTLE: if (tmr_zero_i) begin
        st_n = ST_ISSUE; tmr_load_o = 1'b1; tmr_val_o = cur_hold_i - 1'b1;
      end
      ST_ISSUE: if (tmr_zero_i) begin
        st_n = ST_GAP; tmr_load_o = 1'b1; tmr_val_o = CNT_W'(GAP_CYC - 1);
        if (idx_q != LAST_IDX)          idx_n = idx_q + 1'b1;
        else if (!rank_q && dual_q)     begin idx_n = '0; rank_n = 1'b1; end
        else                            fin_n = 1'b1;
      end
      ST_GAP: if (tmr_zero_i) begin
        if (fin_q) st_n = ST_DONE;
        else begin
          st_n = ST_ISSUE; tmr_load_o = 1'b1; tmr_val_o = cur_hold_i - 1'b1;
        end
      end
      ST_DONE: st_n = ST_IDLE;
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; idx_q <= '0; rank_q <= 1'b0; dual_q <= 1'b0; fin_q <= 1'b0;
    end else begin
      st_q <= st_n; idx_q <= idx_n; rank_q <= rank_n; dual_q <= dual_n; fin_q <= fin_n;
    end
  end

  assign state_o = st_q;
  assign idx_o   = idx_q;
  assign rank_o  = rank_q;

  // R9
  settle_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SETTLE && $past(st_q) != ST_SETTLE) |-> $past(st_q) == ST_IDLE);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_q == ST_DONE |=> st_q == ST_IDLE);

  // R3
  order_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_GAP && $past(st_q) == ST_ISSUE && !fin_q) |->
      (idx_q == $past(idx_q) + 1'b1) || (idx_q == '0 && rank_q && !$past(rank_q)));

  // R7
  rank1_dual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rank_q |-> dual_q);

  // R10
  dual_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_IDLE && $past(st_q) != ST_IDLE) |-> $stable(dual_q));
endmodule

// File: rtl/mrinit_seq.sv
module mrinit_seq
  import mrinit_pkg::*;
#(
  parameter int unsigned SETTLE_CYC     = 40000,
  parameter int unsigned LONG_HOLD_CYC  = 2000,
  parameter int unsigned SHORT_HOLD_CYC = 200,
  parameter int unsigned GAP_CYC        = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              chan_sel_i,
  input  logic [31:0]       rank_cfg_i,
  input  logic [27:0]       mr_reset_val_i,
  input  logic [27:0]       mr_zqinit_val_i,
  input  logic [27:0]       mr_iostr_val_i,
  input  logic [27:0]       mr_cfga_val_i,
  input  logic [27:0]       mr_cfgb_val_i,
  input  logic [27:0]       mr_odt_val_i,
  output logic [31:0]       cmd_word_o,
  output logic              cmd_req_o,
  output logic              done_o
);
  localparam int unsigned MAX_CYC = max4(SETTLE_CYC, LONG_HOLD_CYC, SHORT_HOLD_CYC, GAP_CYC);
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

  seq_state_t       state;
  logic [IDX_W-1:0] cmd_idx;
  logic             cur_rank, dual_cfg;
  logic             tmr_load, tmr_zero;
  logic [CNT_W-1:0] tmr_val, tmr_cnt, cur_hold;
  logic [VAL_W-1:0] cur_val;
  logic             unused_cfg;

  assign dual_cfg   = dual_from_cfg(rank_cfg_i, chan_sel_i);
  assign unused_cfg = ^{rank_cfg_i[31:18], rank_cfg_i[15:0], tmr_cnt};

  mrinit_ctrl #(.CNT_W(CNT_W), .SETTLE_CYC(SETTLE_CYC), .GAP_CYC(GAP_CYC)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .dual_cfg_i(dual_cfg),
    .tmr_zero_i(tmr_zero), .cur_hold_i(cur_hold), .state_o(state),
    .idx_o(cmd_idx), .rank_o(cur_rank), .tmr_load_o(tmr_load), .tmr_val_o(tmr_val)
  );

  mrinit_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load_i(tmr_load), .load_val_i(tmr_val),
    .cnt_o(tmr_cnt), .zero_o(tmr_zero)
  );

  mrinit_cmdrom #(.CNT_W(CNT_W), .LONG_HOLD_CYC(LONG_HOLD_CYC),
                  .SHORT_HOLD_CYC(SHORT_HOLD_CYC)) u_rom (
    .idx_i(cmd_idx), .reset_val_i(mr_reset_val_i), .zqinit_val_i(mr_zqinit_val_i),
    .iostr_val_i(mr_iostr_val_i), .cfga_val_i(mr_cfga_val_i), .cfgb_val_i(mr_cfgb_val_i),
    .odt_val_i(mr_odt_val_i), .val_o(cur_val), .hold_o(cur_hold)
  );

  assign cmd_req_o  = (state == ST_ISSUE);
  assign done_o     = (state == ST_DONE);
  assign cmd_word_o = cmd_req_o ? pack_cmd(cur_rank, cur_val) : '0;

  // Independent run-length counter of strobe-high cycles, for the hold check
  logic [CNT_W-1:0] hi_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         hi_run <= '0;
    else if (cmd_req_o) hi_run <= hi_run + 1'b1;
    else                hi_run <= '0;
  end

  // R5
  hold_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cmd_req_o) |-> hi_run == $past(cur_hold));

  // R6
  idle_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_req_o |-> cmd_word_o == '0);

  // R4
  word_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_req_o && $past(cmd_req_o)) |-> $stable(cmd_word_o));
endmodule

// File: tb/sim_mrinit_seq.sv
module sim_mrinit_seq;
  localparam int S = 40, L = 12, SH = 4, G = 2;

  logic        clk = 0, rst_n = 0, start_i = 0, chan_sel_i = 0;
  logic [31:0] rank_cfg_i = '0;
  logic [27:0] vals [6];
  logic [31:0] cmd_word_o;
  logic        cmd_req_o, done_o;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int nep = 0, ndone = 0, done_cyc = 0, idle_bad = 0, unstable = 0;
  int ep_start [16];
  int ep_len   [16];
  logic [31:0] ep_word [16];
  logic prev_req = 0, mon_en = 0;

  always #2.5 clk = ~clk;

  mrinit_seq #(.SETTLE_CYC(S), .LONG_HOLD_CYC(L), .SHORT_HOLD_CYC(SH), .GAP_CYC(G)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .chan_sel_i(chan_sel_i),
    .rank_cfg_i(rank_cfg_i), .mr_reset_val_i(vals[0]), .mr_zqinit_val_i(vals[1]),
    .mr_iostr_val_i(vals[2]), .mr_cfga_val_i(vals[3]), .mr_cfgb_val_i(vals[4]),
    .mr_odt_val_i(vals[5]), .cmd_word_o(cmd_word_o), .cmd_req_o(cmd_req_o), .done_o(done_o)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) if (mon_en) begin
    if (cmd_req_o) begin
      if (!prev_req) begin
        if (nep < 16) begin ep_start[nep] = cyc; ep_word[nep] = cmd_word_o; ep_len[nep] = 1; end
        nep++;
      end else if (nep <= 16) begin
        ep_len[nep-1]++;
        if (cmd_word_o != ep_word[nep-1]) unstable++;
      end
    end else if (cmd_word_o != '0) idle_bad++;
    if (done_o) begin done_cyc = cyc; ndone++; end
    prev_req = cmd_req_o;
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic test_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R1 req in reset", {31'd0, cmd_req_o}, 32'd0);
    chk("R1 done in reset", {31'd0, done_o}, 32'd0);
    chk("R1 word in reset", cmd_word_o, 32'd0);
    rst_n = 1;
    mon_en = 1;
    repeat (S + 10) @(negedge clk);
    chk("R1 no activity without start", nep, 0);
    chk("R1 no done without start", ndone, 0);
  endtask

  // restart_at: cycles after start for a second pulse (0 = none)
  // cfg_after: configuration applied right after the start pulse
  task automatic run_seq(string name, logic chan, logic [31:0] cfg, logic exp_dual,
                         int restart_at, logic [31:0] cfg_after);
    int k0, n_exp, guard, expect_t, hold;
    nep = 0; ndone = 0; idle_bad = 0; unstable = 0; done_cyc = 0;
    chan_sel_i = chan; rank_cfg_i = cfg;
    @(negedge clk);
    start_i = 1; k0 = cyc + 1;
    @(negedge clk);
    start_i = 0; rank_cfg_i = cfg_after;
    if (restart_at > 0) begin
      repeat (restart_at) @(negedge clk);
      start_i = 1;
      @(negedge clk);
      start_i = 0;
    end
    guard = 0;
    while (ndone == 0 && guard < 2000) begin @(negedge clk); guard++; end
    repeat (S + 20) @(negedge clk);
    n_exp = exp_dual ? 12 : 6;
    chk({name, " R7 command count"}, nep, n_exp);
    chk({name, " R8 single done pulse"}, ndone, 1);
    chk({name, " R2 settle delay"}, ep_start[0], k0 + S);
    expect_t = k0 + S;
    for (int i = 0; i < n_exp && i < nep; i++) begin
      hold = (i % 6 == 0) ? L : SH;
      chk({name, " R3 R4 command word"}, ep_word[i],
          {((i >= 6) ? 4'd1 : 4'd0), vals[i % 6]});
      chk({name, " R5 hold length"}, ep_len[i], hold);
      chk({name, " R6 strobe spacing"}, ep_start[i], expect_t);
      expect_t = expect_t + hold + G;
    end
    chk({name, " R8 done timing"}, done_cyc, expect_t);
    chk({name, " R6 idle word zero"}, idle_bad, 0);
    chk({name, " R4 word stable"}, unstable, 0);
  endtask

  initial begin
    vals[0] = 28'h000_0FC3; vals[1] = 28'h000_FF0A; vals[2] = 28'h000_0203;
    vals[3] = 28'h000_8301; vals[4] = 28'h000_0602; vals[5] = 28'h000_000B;
    test_reset();
    run_seq("single ch0", 1'b0, 32'h0001_0000, 1'b0, 0, 32'h0001_0000);
    run_seq("dual ch0",   1'b0, 32'h0002_0000, 1'b1, 0, 32'h0002_0000);
    run_seq("dual ch1",   1'b1, 32'h0001_0000, 1'b1, 0, 32'h0001_0000);
    run_seq("single ch1", 1'b1, 32'h0002_0000, 1'b0, 0, 32'h0002_0000);
    run_seq("busy start R9", 1'b0, 32'h0002_0000, 1'b1, 60, 32'h0002_0000);
    run_seq("busy start in settle R9", 1'b0, 32'h0, 1'b0, 5, 32'h0);
    run_seq("cfg change R10", 1'b0, 32'h0, 1'b0, 0, 32'h0003_0000);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(150000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule